// File: doc/BRIEF.md
# SD Command Line Controller

This block is the host end of the command wire on an MMC/SD bus. A start strobe captures a 6-bit command index, a 32-bit argument, a response kind and a drive-mode flag. The block then shifts out a 48-bit command frame with its CRC7 appended. When the frame is finished it stops driving the wire, counts the clocks of the turnaround and pull-up gap, and watches for the card's start bit inside a bounded window. It then collects a short (48-bit) or long (136-bit) response and reports the framing and CRC checks on it.

The wire is driven open-drain while cards are still being identified and have no address. In that mode the host pulls the wire low for zeros and releases it for ones. Once a card has an address, the caller selects push-pull and the host drives every bit. A one-cycle `done` marks the end of each transaction. The error flags and the captured response stay valid until the next start strobe. Clock generation, data lines and card state are handled elsewhere.

States: `S_IDLE` (waits for the strobe; strobe → `S_SEND`), `S_SEND` (48 command bits; last bit → `S_TURN`, or → `S_FINISH` when no response is wanted), `S_TURN` (the first turnaround cycles with the wire released), `S_WAIT` (pull-up cycles until the start bit). From `S_TURN` and `S_WAIT` an accepted start bit goes to `S_RECV`, and the end of the window goes to `S_FINISH`. `S_RECV` collects the response bits; its last bit → `S_FINISH`. `S_FINISH` is the done cycle and always returns to `S_IDLE`.

Top module: `sd_cmd_engine`

## Requirements
- R1: The first command bit is on the wire in the cycle after the strobe is sampled. One bit follows per cycle in this order: bit 0 = 0, bit 1 = 1, bits 2–7 = index MSB first, bits 8–39 = argument MSB first, bits 40–46 = CRC7 MSB first, bit 47 = 1. The CRC7 uses x^7+x^3+1, starts from zero and covers bits 0–39.
- R2: With the open-drain flag set, `cmd_oe` is high only during command bits that are 0, and `cmd_out` is 0 whenever `cmd_oe` is high. With the flag clear, `cmd_oe` is high for all 48 command bits and `cmd_out` carries each bit.
- R3: From the cycle after the end bit until the next strobe, `cmd_oe` stays low.
- R4: Gap cycle 1 is the first cycle after the end bit. A low on `cmd_in` sampled in gap cycle g is taken as the card's start bit when g ≥ MIN_GAP (default 2). Lows in earlier gap cycles are ignored.
- R5: If no start bit is taken by gap cycle MAX_GAP (default 64), `done` and `timeout` rise in the next cycle, with `resp_data` zero and the other flags clear.
- R6: Response kind 2'b01 expects 48 bits. `done` rises in the cycle after the end bit is sampled. `resp_data[44:0]` then holds the received {index, argument, CRC}, and the upper bits are zero.
- R7: Response kinds 2'b10 and 2'b11 expect 136 bits. `resp_data[126:0]` holds the 120 content bits that follow the 8 header bits, then the received CRC. Bit 127 is zero.
- R8: `crc_err` is set when the received CRC differs from the CRC7 (zero start) of response bits 2–39 for a short response, or bits 8–127 for a long one.
- R9: `frame_err` is set when response bit 1 (the transmitter bit) is 1 or the end bit is 0.
- R10: With response kind 2'b00, `done` rises in gap cycle 1 and all flags are clear.
- R11: `done` lasts exactly one cycle. The flags and `resp_data` hold their values until the next strobe, which clears them. After reset all outputs are low except `cmd_out`.
- R12: A strobe that arrives while a transaction is running is ignored, and the frame in flight is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-side clock; `cmd_in` is sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Strobe that begins a transaction (sampled in idle only) |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| resp_kind | input | 2 | 00 none, 01 short, 10/11 long |
| open_drain | input | 1 | 1: drive zeros only; 0: push-pull |
| cmd_in | input | 1 | Level of the command wire |
| cmd_out | output | 1 | Value driven onto the wire |
| cmd_oe | output | 1 | Output enable for the wire |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | No start bit inside the window |
| crc_err | output | 1 | Response CRC mismatch |
| frame_err | output | 1 | Bad transmitter bit or end bit |
| resp_data | output | 128 | Captured response, right-aligned |

## Verification
The hardest cases to reach from the ports are the edges of the response window: a start bit in exactly gap cycle MIN_GAP or MAX_GAP, and a stray low in a gap cycle before MIN_GAP. The bench plays the card on `cmd_in`, clock by clock, from the cycle after the end bit. It moves the start bit across every gap cycle from MIN_GAP to MAX_GAP, pulls the wire low in gap cycle 1 both before a real response and with no response following, and corrupts the CRC, transmitter bit and end bit one at a time.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
    localparam int IDX_W       = 6;
    localparam int ARG_W       = 32;
    localparam int CRC_W       = 7;
    localparam int BODY_BITS   = 2 + IDX_W + ARG_W;          // start .. argument
    localparam int FRAME_BITS  = BODY_BITS + CRC_W + 1;      // 48
    localparam int LONG_BITS   = 136;
    localparam int SHORT_HDR   = 2;
    localparam int LONG_HDR    = 8;
    localparam int RX_W        = LONG_BITS - LONG_HDR - 1;   // 127
    localparam int RESP_W      = 128;
    localparam int CNT_W       = $clog2(LONG_BITS + 1);
    localparam int CRC_IDX_W   = $clog2(CRC_W);

    typedef enum logic [2:0] {
        S_IDLE,
        S_SEND,
        S_TURN,
        S_WAIT,
        S_RECV,
        S_FINISH
    } sdc_state_t;
endpackage

// File: rtl/sdc_crc7.sv
module sdc_crc7
    import sdc_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = 7'h09
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             din,
    output logic [CRC_W-1:0] crc
);
    logic feedback;
    assign feedback = din ^ crc[CRC_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc <= '0;
        end else if (clr) begin
            crc <= '0;
        end else if (en) begin
            crc <= {crc[CRC_W-2:0], 1'b0} ^ (POLY & {CRC_W{feedback}});
        end
    end

    // A zero fed into a cleared register keeps it cleared (leading bits of frames).
    assert_zero_keeps_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && !din && crc == '0) |=> crc == '0);
endmodule

// File: rtl/sdc_gap_timer.sv
module sdc_gap_timer #(
    parameter int MAX_GAP = 64,
    parameter int GAP_W   = $clog2(MAX_GAP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             inc,
    output logic [GAP_W-1:0] gap
);
    localparam logic [GAP_W-1:0] G_MAX = GAP_W'(MAX_GAP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap <= '0;
        end else if (load) begin
            gap <= GAP_W'(1);
        end else if (inc && gap != G_MAX) begin
            gap <= gap + GAP_W'(1);
        end
    end

    assert_gap_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && gap < G_MAX) |=> gap == $past(gap) + GAP_W'(1));
    assert_gap_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        gap <= G_MAX);
endmodule

// File: rtl/sdc_rx_shift.sv
module sdc_rx_shift #(
    parameter int W = 127
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
        end else if (clr) begin
            data <= '0;
        end else if (en) begin
            data <= {data[W-2:0], din};
        end
    end

    assert_shift_in_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |=> data[0] == $past(din));
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
    import sdc_pkg::*;
#(
    parameter int MIN_GAP     = 2,
    parameter int MAX_GAP     = 64,
    parameter int TURN_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W-1:0]  cmd_index,
    input  logic [ARG_W-1:0]  cmd_arg,
    input  logic [1:0]        resp_kind,
    input  logic              open_drain,
    input  logic              cmd_in,
    output logic              cmd_out,
    output logic              cmd_oe,
    output logic              done,
    output logic              timeout,
    output logic              crc_err,
    output logic              frame_err,
    output logic [RESP_W-1:0] resp_data
);
    localparam int GAP_W = $clog2(MAX_GAP + 1);
    localparam logic [GAP_W-1:0] G_MIN  = GAP_W'(MIN_GAP);
    localparam logic [GAP_W-1:0] G_MAX  = GAP_W'(MAX_GAP);
    localparam logic [GAP_W-1:0] G_TURN = GAP_W'(TURN_CYCLES);

    localparam logic [CNT_W-1:0] C_ONE        = CNT_W'(1);
    localparam logic [CNT_W-1:0] C_BODY       = CNT_W'(BODY_BITS);
    localparam logic [CNT_W-1:0] C_TX_LAST    = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] C_TX_CRC_TOP = CNT_W'(FRAME_BITS - 2);
    localparam logic [CNT_W-1:0] C_S_LAST     = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] C_L_LAST     = CNT_W'(LONG_BITS - 1);
    localparam logic [CNT_W-1:0] C_S_HDR      = CNT_W'(SHORT_HDR);
    localparam logic [CNT_W-1:0] C_L_HDR      = CNT_W'(LONG_HDR);
    localparam logic [CNT_W-1:0] C_S_CRC_LAST = CNT_W'(FRAME_BITS - CRC_W - 2);
    localparam logic [CNT_W-1:0] C_L_CRC_LAST = CNT_W'(LONG_BITS - CRC_W - 2);

    sdc_state_t state_q, state_d;

    logic [CNT_W-1:0]     cnt_q;
    logic [BODY_BITS-1:0] frame_q;
    logic                 od_q, long_q, none_q;
    logic                 timeout_q, crc_err_q, frame_err_q;
    logic [GAP_W-1:0]     gap;
    logic [CRC_W-1:0]     crc_q;
    logic [RX_W-1:0]      rx_q;

    logic                 launch, listening, accept, tx_bit;
    logic                 crc_en, crc_din, crc_clr, rx_en, gap_load, gap_inc;
    logic [CNT_W-1:0]     rx_last, rx_hdr, rx_crc_last;
    logic [CRC_IDX_W-1:0] crc_idx;

    // ---------------------------------------------------------------
    // Shared decode
    // ---------------------------------------------------------------
    assign launch    = (state_q == S_IDLE) && start;
    assign listening = (state_q == S_TURN) || (state_q == S_WAIT);
    assign accept    = listening && (gap >= G_MIN) && !cmd_in;

    assign rx_last     = long_q ? C_L_LAST     : C_S_LAST;
    assign rx_hdr      = long_q ? C_L_HDR      : C_S_HDR;
    assign rx_crc_last = long_q ? C_L_CRC_LAST : C_S_CRC_LAST;

    assign crc_idx = CRC_IDX_W'(C_TX_CRC_TOP - cnt_q);

    always_comb begin
        if (cnt_q < C_BODY) begin
            tx_bit = frame_q[BODY_BITS-1];
        end else if (cnt_q < C_TX_LAST) begin
            tx_bit = crc_q[crc_idx];
        end else begin
            tx_bit = 1'b1;
        end
    end

    assign crc_en  = ((state_q == S_SEND) && (cnt_q < C_BODY))
                  || ((state_q == S_RECV) && (cnt_q >= rx_hdr) && (cnt_q <= rx_crc_last));
    assign crc_din = (state_q == S_SEND) ? tx_bit : cmd_in;
    assign crc_clr = launch || accept;

    assign rx_en    = (state_q == S_RECV) && (cnt_q >= rx_hdr) && (cnt_q < rx_last);
    assign gap_load = (state_q == S_SEND) && (cnt_q == C_TX_LAST);
    assign gap_inc  = listening && !accept;

    // ---------------------------------------------------------------
    // Sub-blocks
    // ---------------------------------------------------------------
    sdc_crc7 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .en    (crc_en),
        .din   (crc_din),
        .crc   (crc_q)
    );

    sdc_gap_timer #(
        .MAX_GAP (MAX_GAP),
        .GAP_W   (GAP_W)
    ) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (gap_load),
        .inc   (gap_inc),
        .gap   (gap)
    );

    sdc_rx_shift #(
        .W (RX_W)
    ) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (launch),
        .en    (rx_en),
        .din   (cmd_in),
        .data  (rx_q)
    );

    // ---------------------------------------------------------------
    // Next state
    // ---------------------------------------------------------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = S_SEND;
            S_SEND:   if (cnt_q == C_TX_LAST) state_d = none_q ? S_FINISH : S_TURN;
            S_TURN,
            S_WAIT: begin
                if (accept)              state_d = S_RECV;
                else if (gap == G_MAX)   state_d = S_FINISH;
                else if (gap >= G_TURN)  state_d = S_WAIT;
                else                     state_d = S_TURN;
            end
            S_RECV:   if (cnt_q == rx_last) state_d = S_FINISH;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // ---------------------------------------------------------------
    // Datapath registers
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            frame_q     <= '0;
            od_q        <= 1'b0;
            long_q      <= 1'b0;
            none_q      <= 1'b0;
            timeout_q   <= 1'b0;
            crc_err_q   <= 1'b0;
            frame_err_q <= 1'b0;
        end else if (launch) begin
            cnt_q       <= '0;
            frame_q     <= {1'b0, 1'b1, cmd_index, cmd_arg};
            od_q        <= open_drain;
            long_q      <= resp_kind[1];
            none_q      <= (resp_kind == 2'b00);
            timeout_q   <= 1'b0;
            crc_err_q   <= 1'b0;
            frame_err_q <= 1'b0;
        end else begin
            case (state_q)
                S_SEND: begin
                    cnt_q   <= cnt_q + C_ONE;
                    frame_q <= {frame_q[BODY_BITS-2:0], 1'b0};
                end
                S_TURN, S_WAIT: begin
                    if (accept)            cnt_q     <= C_ONE;
                    else if (gap == G_MAX) timeout_q <= 1'b1;
                end
                S_RECV: begin
                    cnt_q <= cnt_q + C_ONE;
                    if (cnt_q == C_ONE && cmd_in) frame_err_q <= 1'b1;
                    if (cnt_q == rx_last) begin
                        if (!cmd_in)                 frame_err_q <= 1'b1;
                        if (rx_q[CRC_W-1:0] != crc_q) crc_err_q   <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // ---------------------------------------------------------------
    // Outputs
    // ---------------------------------------------------------------
    always_comb begin
        cmd_oe  = 1'b0;
        cmd_out = 1'b1;
        done    = 1'b0;
        unique case (state_q)
            S_SEND: begin
                if (od_q) begin
                    cmd_oe  = !tx_bit;
                    cmd_out = 1'b0;
                end else begin
                    cmd_oe  = 1'b1;
                    cmd_out = tx_bit;
                end
            end
            S_FINISH: done = 1'b1;
            default: ;
        endcase
    end

    assign timeout   = timeout_q;
    assign crc_err   = crc_err_q;
    assign frame_err = frame_err_q;
    assign resp_data = {{(RESP_W-RX_W){1'b0}}, rx_q};

    // ---------------------------------------------------------------
    // Assertions
    // ---------------------------------------------------------------
    assert_od_low_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (od_q && cmd_oe) |-> !cmd_out);
    assert_release_after_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state_q == S_SEND && cnt_q == C_TX_LAST) |-> !cmd_oe);
    assert_timeout_alone_R5: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (!crc_err && !frame_err));
    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_flags_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !start) |=>
            ($stable(timeout) && $stable(crc_err) && $stable(frame_err) && $stable(resp_data)));
    assert_busy_ignores_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SEND && cnt_q < C_TX_LAST && start) |=> state_q == S_SEND);
endmodule

// File: tb/sd_cmd_engine_bench.sv
module sd_cmd_engine_bench;
    localparam int MIN_GAP = 2;
    localparam int MAX_GAP = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [5:0]   cmd_index = '0;
    logic [31:0]  cmd_arg = '0;
    logic [1:0]   resp_kind = '0;
    logic         open_drain = 1'b0;
    logic         card_oe = 1'b0;
    logic         card_val = 1'b1;
    logic         cmd_in;
    logic         cmd_out, cmd_oe, done, timeout, crc_err, frame_err;
    logic [127:0] resp_data;

    int n_checks = 0;
    int n_err = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    assign cmd_in = card_oe ? card_val : (cmd_oe ? cmd_out : 1'b1);

    sd_cmd_engine #(.MIN_GAP(MIN_GAP), .MAX_GAP(MAX_GAP), .TURN_CYCLES(2)) u_sd_cmd_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_index(cmd_index), .cmd_arg(cmd_arg),
        .resp_kind(resp_kind), .open_drain(open_drain), .cmd_in(cmd_in), .cmd_out(cmd_out),
        .cmd_oe(cmd_oe), .done(done), .timeout(timeout), .crc_err(crc_err),
        .frame_err(frame_err), .resp_data(resp_data)
    );

    task automatic chk(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (ok !== 1'b1) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] crc7(input logic [119:0] v, input int n);
        logic [6:0] c;
        logic fb;
        c = '0;
        for (int b = n - 1; b >= 0; b--) begin
            fb = v[b] ^ c[6];
            c = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

    function automatic logic [135:0] short_rsp(input logic [5:0] i, input logic [31:0] a,
                                                input logic txb, input logic endb, input logic [6:0] flip);
        logic [6:0] c;
        c = crc7({82'b0, i, a}, 38) ^ flip;
        return {88'b0, 1'b0, txb, i, a, c, endb};
    endfunction

    function automatic logic [127:0] short_exp(input logic [5:0] i, input logic [31:0] a, input logic [6:0] flip);
        logic [6:0] c;
        c = crc7({82'b0, i, a}, 38) ^ flip;
        return {83'b0, i, a, c};
    endfunction

    function automatic logic [135:0] long_rsp(input logic [119:0] body, input logic [6:0] flip);
        return {8'b0011_1111, body, crc7(body, 120) ^ flip, 1'b1};
    endfunction

    function automatic logic [127:0] long_exp(input logic [119:0] body, input logic [6:0] flip);
        return {1'b0, body, crc7(body, 120) ^ flip};
    endfunction

    task automatic run_cmd(input logic [5:0] i, input logic [31:0] a, input logic [1:0] k, input logic o,
                           input int gap_at, input int early, input logic [135:0] rsp, input int rlen,
                           input logic e_ce, input logic e_fe, input logic [127:0] e_data, input logic poke);
        logic [47:0] tx48;
        logic expb, line;
        string dreq;
        tx48 = {1'b0, 1'b1, i, a, crc7({80'b0, 1'b0, 1'b1, i, a}, 40), 1'b1};
        dreq = (rlen == 48) ? "R6" : "R7";
        @(negedge clk);
        start = 1'b1; cmd_index = i; cmd_arg = a; resp_kind = k; open_drain = o;
        @(negedge clk);
        start = 1'b0;
        for (int b = 0; b < 48; b++) begin
            expb = tx48[47-b];
            line = cmd_oe ? cmd_out : 1'b1;
            chk(line == expb, "R1", 128'(line), 128'(expb));
            if (o) chk((cmd_oe == !expb) && !(cmd_oe && cmd_out), "R2", {cmd_oe, cmd_out}, {!expb, 1'b0});
            else   chk(cmd_oe == 1'b1, "R2", 128'(cmd_oe), 128'd1);
            if (b == 0) chk({timeout, crc_err, frame_err} == 3'b0 && resp_data == '0, "R11",
                            {timeout, crc_err, frame_err, resp_data[124:0]}, '0);
            if (poke && b == 10) begin start = 1'b1; cmd_index = ~i; end
            else begin start = 1'b0; cmd_index = i; end
            @(negedge clk);
        end
        start = 1'b0;
        if (k == 2'b00) begin
            chk(done == 1'b1, "R10", 128'(done), 128'd1);
            chk(!cmd_oe, "R3", 128'(cmd_oe), 128'd0);
            chk({timeout, crc_err, frame_err} == 3'b0, "R10", {timeout, crc_err, frame_err}, '0);
            @(negedge clk);
            chk(done == 1'b0, "R11", 128'(done), 128'd0);
        end else if (gap_at == 0) begin
            for (int g = 1; g <= MAX_GAP; g++) begin
                card_oe = (g == early); card_val = 1'b0;
                chk(!done && !cmd_oe, "R3", {done, cmd_oe}, '0);
                @(negedge clk);
            end
            card_oe = 1'b0;
            chk(done && timeout, "R5", {done, timeout}, 128'b11);
            chk(!crc_err && !frame_err && resp_data == '0, "R5", {crc_err, frame_err, resp_data[125:0]}, '0);
            @(negedge clk);
            chk(!done && timeout, "R11", {done, timeout}, 128'b01);
        end else begin
            for (int g = 1; g < gap_at; g++) begin
                card_oe = (g == early); card_val = 1'b0;
                chk(!cmd_oe && !done, "R4", {cmd_oe, done}, '0);
                @(negedge clk);
            end
            for (int b = 0; b < rlen; b++) begin
                card_oe = 1'b1; card_val = rsp[rlen-1-b];
                chk(!cmd_oe && !done, "R3", {cmd_oe, done}, '0);
                @(negedge clk);
            end
            card_oe = 1'b0;
            chk(done == 1'b1, dreq, 128'(done), 128'd1);
            chk(resp_data == e_data, dreq, resp_data, e_data);
            chk(crc_err == e_ce, "R8", 128'(crc_err), 128'(e_ce));
            chk(frame_err == e_fe, "R9", 128'(frame_err), 128'(e_fe));
            chk(timeout == 1'b0, "R5", 128'(timeout), 128'd0);
            @(negedge clk);
            chk(done == 1'b0, "R11", 128'(done), 128'd0);
            repeat (3) @(negedge clk);
            chk(resp_data == e_data && crc_err == e_ce && frame_err == e_fe, "R11",
                {crc_err, frame_err, resp_data[125:0]}, {e_ce, e_fe, e_data[125:0]});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        logic [119:0] body;
        repeat (3) @(negedge clk);
        chk({done, cmd_oe, timeout, crc_err, frame_err} == 5'b0 && resp_data == '0, "R11",
            {done, cmd_oe, timeout, crc_err, frame_err, resp_data[122:0]}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // Commands without a response, both drive modes (R1, R2, R10)
        for (int n = 0; n < 8; n++)
            run_cmd(6'(n * 9 + 1), 32'hA5C3_0F1E ^ (32'(n) * 32'h0123_4567), 2'b00, n[0],
                    0, 0, '0, 0, 1'b0, 1'b0, '0, 1'b0);

        // Short responses with the start bit in every legal gap cycle (R4, R6)
        for (int g = MIN_GAP; g <= MAX_GAP; g++)
            run_cmd(6'(g + 3), 32'(g) * 32'h0101_0033, 2'b01, g[0], g, 0,
                    short_rsp(6'(g), 32'hDEAD_0000 + 32'(g * 77), 1'b0, 1'b1, 7'h0), 48,
                    1'b0, 1'b0, short_exp(6'(g), 32'hDEAD_0000 + 32'(g * 77), 7'h0), 1'b0);

        // Early low in gap cycle 1 ignored, real start later (R4)
        run_cmd(6'd41, 32'h1357_9BDF, 2'b01, 1'b1, 6, 1,
                short_rsp(6'd41, 32'hCAFE_F00D, 1'b0, 1'b1, 7'h0), 48,
                1'b0, 1'b0, short_exp(6'd41, 32'hCAFE_F00D, 7'h0), 1'b0);
        // Early low only, then silence: must time out (R4, R5)
        run_cmd(6'd2, 32'h0, 2'b01, 1'b1, 0, 1, '0, 0, 1'b0, 1'b0, '0, 1'b0);
        // Plain timeout in push-pull (R5)
        run_cmd(6'd8, 32'hFFFF_FFFF, 2'b10, 1'b0, 0, 0, '0, 0, 1'b0, 1'b0, '0, 1'b0);

        // Corrupted short responses (R8, R9)
        run_cmd(6'd17, 32'h0BAD_C0DE, 2'b01, 1'b0, 3, 0,
                short_rsp(6'd17, 32'h0BAD_C0DE, 1'b0, 1'b1, 7'h01), 48,
                1'b1, 1'b0, short_exp(6'd17, 32'h0BAD_C0DE, 7'h01), 1'b0);
        run_cmd(6'd18, 32'h1111_2222, 2'b01, 1'b0, 4, 0,
                short_rsp(6'd18, 32'h3333_4444, 1'b1, 1'b1, 7'h0), 48,
                1'b0, 1'b1, short_exp(6'd18, 32'h3333_4444, 7'h0), 1'b0);
        run_cmd(6'd19, 32'h5555_6666, 2'b01, 1'b1, 5, 0,
                short_rsp(6'd19, 32'h7777_8888, 1'b0, 1'b0, 7'h0), 48,
                1'b0, 1'b1, short_exp(6'd19, 32'h7777_8888, 7'h0), 1'b0);

        // Long responses (R7, R8)
        body = {4{30'h1234_5678}};
        run_cmd(6'd2, 32'h0, 2'b10, 1'b1, 5, 0, long_rsp(body, 7'h0), 136,
                1'b0, 1'b0, long_exp(body, 7'h0), 1'b0);
        body = {3{40'h9A_BCDE_F012}};
        run_cmd(6'd9, 32'h0001_0000, 2'b11, 1'b0, MAX_GAP, 0, long_rsp(body, 7'h40), 136,
                1'b1, 1'b0, long_exp(body, 7'h40), 1'b0);

        // Strobe during the frame is ignored (R12)
        run_cmd(6'd55, 32'h8421_1248, 2'b00, 1'b0, 0, 0, '0, 0, 1'b0, 1'b0, '0, 1'b1);
        run_cmd(6'd12, 32'h0F0F_F0F0, 2'b01, 1'b1, 2, 0,
                short_rsp(6'd12, 32'h0F0F_F0F0, 1'b0, 1'b1, 7'h0), 48,
                1'b0, 1'b0, short_exp(6'd12, 32'h0F0F_F0F0, 7'h0), 1'b1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule